// File: doc/BRIEF.md
# DMA Transfer Byte Counter

This block keeps the remaining byte count of a peripheral DMA engine and decides when a transfer ends. A host fills a 32-bit total through four byte-wide register writes, lowest byte first. The working counter takes the new total only on the write to the most significant byte; the three lower writes only fill a staging register. Any read of a count byte returns the live remaining count, so software can poll progress.

An 8-bit command starts a transfer. The command picks one of four modes and a direction. While the transfer is active, each accepted data beat lowers the count. A PIO beat carries 16 bits and lowers the count by two; beats in every other mode lower it by one. When the count reaches zero, the transfer ends with a one-cycle done pulse. In the generic mode, with the slave option and the counter-disable option both set, the count is frozen and an external end-of-transfer input ends the transfer instead, which also flags the last packet as valid. Other commands reset the whole block or stop a multi-word transfer. All remaining codes have no effect.

Beats arrive on a valid/ready pair. `beat_ready` is high only while a transfer is active and can still take data: either the count is non-zero, or the transfer ends on the external input. A beat counts only on a cycle where both `beat_valid` and `beat_ready` are high. When `beat_ready` is low, the source holds its beat. `beat_valid` low never changes the count.

Top module: `dma_xfer_counter`

## Requirements
- R1: `reg_rdata` shows byte `reg_addr` of the live 32-bit count in the same cycle. Address 0 holds bits 7:0 and address 3 holds bits 31:24.
- R2: A write to address 0, 1 or 2 changes only the staging register. A write to address 3 loads the counter with {written byte, staged bits 23:0} on that clock edge.
- R3: While `rst_n` is low, or on any cycle with `bus_rst` high, the count, the staging bytes, the mode and the active flag all go to zero. `beat_ready`, `xfer_done` and `last_pkt_valid` are then low.
- R4: Command codes 00h to 07h start a transfer on the next edge. `xfer_active` goes to 1, `xfer_mode` takes code bits 2:1 (0 generic, 1 ultra, 2 PIO, 3 multi-word) and `xfer_dir` takes code bit 0 (1 = transmit). The count is kept.
- R5: An accepted beat lowers the count by 2 in PIO mode and by 1 in the other modes.
- R6: If a beat's step is larger than the remaining count, the count saturates at zero.
- R7: When the count is zero during an active counted transfer, the next edge clears `xfer_active` and raises `xfer_done` for exactly that cycle. A transfer of N bytes therefore takes N beats, or ceil(N/2) beats in PIO mode.
- R8: Command 11h clears the count, the staging bytes, the mode and the active flag.
- R9: Command 12h ends an active multi-word transfer at once, without a done pulse and keeping the count. In any other mode it has no effect.
- R10: Codes 08h to 10h and 13h to FFh change neither the count, the mode nor the active state.
- R11: When `cfg_cnt_dis` and `cfg_slave` are both set and the mode is generic, accepted beats leave the count unchanged. `eot_in` high during the transfer ends it on the next edge, with a one-cycle pulse on both `xfer_done` and `last_pkt_valid`.
- R12: Outside the case in R11, `eot_in` has no effect.
- R13: `beat_ready` is high only during an active transfer that can still take data (count non-zero, or ending on `eot_in`). A cycle with `beat_valid` low leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_rst | input | 1 | Synchronous bus reset, same effect as power-on |
| reg_wr | input | 1 | Count byte write strobe |
| reg_addr | input | 2 | Count byte select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Live count byte |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| cfg_cnt_dis | input | 1 | Counter disable option |
| cfg_slave | input | 1 | Slave operation option |
| beat_valid | input | 1 | Data beat offered |
| beat_ready | output | 1 | Data beat can be accepted |
| eot_in | input | 1 | External end of transfer |
| xfer_active | output | 1 | Transfer in progress |
| xfer_mode | output | 2 | Active mode |
| xfer_dir | output | 1 | Active direction, 1 = transmit |
| xfer_done | output | 1 | One-cycle end-of-transfer pulse |
| last_pkt_valid | output | 1 | One-cycle pulse when the transfer ends on `eot_in` |

## Verification
The counting path is swept over all eight start codes and six totals (0, 1, 2, 3, 4 and 7). This covers the zero-length start, odd totals in PIO mode where saturation matters, and the one-byte versus two-byte step. Inside each sweep, `beat_valid` drops on every third cycle, which separates beats actually taken from cycles merely spent. Directed sequences then cover:
- staged writes against the live read-back;
- reserved codes and the stop command in both multi-word and ultra modes;
- the reset command and bus reset;
- the external end-of-transfer input with the counter disabled, against the same input while the counter is in charge.

// File: rtl/dxc_pkg.sv
package dxc_pkg;
  typedef enum logic [1:0] {
    MODE_GEN   = 2'd0,
    MODE_ULTRA = 2'd1,
    MODE_PIO   = 2'd2,
    MODE_MULTI = 2'd3
  } xfer_mode_e;

  localparam logic [7:0] CMD_START_LAST = 8'h07;
  localparam logic [7:0] CMD_RESET      = 8'h11;
  localparam logic [7:0] CMD_STOP       = 8'h12;
endpackage

// File: rtl/dxc_cmd_decode.sv
module dxc_cmd_decode
  import dxc_pkg::*;
(
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  output logic       is_start,
  output logic       is_reset,
  output logic       is_stop,
  output xfer_mode_e start_mode,
  output logic       start_dir
);
  assign is_start   = cmd_valid && (cmd_code <= CMD_START_LAST);
  assign is_reset   = cmd_valid && (cmd_code == CMD_RESET);
  assign is_stop    = cmd_valid && (cmd_code == CMD_STOP);
  assign start_mode = xfer_mode_e'(cmd_code[2:1]);
  assign start_dir  = cmd_code[0];

  always_comb begin
    AST_CMD_EXCLUSIVE: assert ($onehot0({is_start, is_reset, is_stop})); // R10
  end
endmodule

// File: rtl/dxc_count_reg.sv
module dxc_count_reg #(
  parameter int CNT_W  = 32,
  parameter int BYTE_W = 8,
  parameter int STEP_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       wr,
  input  logic [$clog2(CNT_W/BYTE_W)-1:0] addr,
  input  logic [BYTE_W-1:0]          wdata,
  input  logic                       dec_en,
  input  logic [STEP_W-1:0]          step,
  output logic [CNT_W-1:0]           cnt,
  output logic                       cnt_zero,
  output logic [BYTE_W-1:0]          rd_byte
);
  localparam int NBYTES = CNT_W / BYTE_W;
  localparam int ADDR_W = $clog2(NBYTES);
  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(NBYTES - 1);

  logic [BYTE_W-1:0] stage_q [NBYTES];
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  load_val;
  logic [CNT_W-1:0]  step_ext;
  logic              load;

  assign load     = wr && (addr == TOP_ADDR);
  assign step_ext = CNT_W'(step);

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              stage_q[b] <= '0;
      else if (clr)                            stage_q[b] <= '0;
      else if (wr && addr == ADDR_W'(b))       stage_q[b] <= wdata;
    end
  end

  always_comb begin
    load_val = '0;
    for (int b = 0; b < NBYTES - 1; b++) load_val[b*BYTE_W +: BYTE_W] = stage_q[b];
    load_val[CNT_W-1 -: BYTE_W] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (clr)                  cnt_q <= '0;
    else if (load)                 cnt_q <= load_val;
    else if (dec_en) begin
      if (cnt_q < step_ext)        cnt_q <= '0;
      else                         cnt_q <= cnt_q - step_ext;
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int b = 0; b < NBYTES; b++)
      if (addr == ADDR_W'(b)) rd_byte = cnt_q[b*BYTE_W +: BYTE_W];
  end

  assign cnt      = cnt_q;
  assign cnt_zero = (cnt_q == '0);

  AST_STAGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    wr && addr != TOP_ADDR && !clr && !dec_en |=> $stable(cnt_q)); // R2
  AST_LOAD_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    load && !clr |=> cnt_q[CNT_W-1 -: BYTE_W] == $past(wdata)); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en && !load && !clr && cnt_q < step_ext |=> cnt_q == '0); // R6
  AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en && !load && !clr && cnt_q >= step_ext |=> cnt_q == $past(cnt_q) - $past(step_ext)); // R5
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0 && stage_q[0] == '0); // R8
endmodule

// File: rtl/dxc_xfer_ctrl.sv
module dxc_xfer_ctrl
  import dxc_pkg::*;
#(
  parameter int PIO_STEP = 2,
  parameter int STEP_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              is_start,
  input  logic              is_stop,
  input  xfer_mode_e        start_mode,
  input  logic              start_dir,
  input  logic              cfg_cnt_dis,
  input  logic              cfg_slave,
  input  logic              beat_valid,
  input  logic              eot_in,
  input  logic              cnt_zero,
  output logic              beat_ready,
  output logic              dec_en,
  output logic [STEP_W-1:0] step,
  output logic              active,
  output logic [1:0]        mode,
  output logic              dir,
  output logic              done,
  output logic              last_pkt
);
  xfer_mode_e mode_q;
  logic active_q, dir_q, done_q, last_q;
  logic eot_mode;

  assign eot_mode   = cfg_cnt_dis && cfg_slave && (mode_q == MODE_GEN);
  assign beat_ready = active_q && (eot_mode || !cnt_zero);
  assign dec_en     = beat_valid && beat_ready && !eot_mode;
  assign step       = (mode_q == MODE_PIO) ? STEP_W'(PIO_STEP) : STEP_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      mode_q   <= MODE_GEN;
      dir_q    <= 1'b0;
      done_q   <= 1'b0;
      last_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      last_q <= 1'b0;
      if (clr) begin
        active_q <= 1'b0;
        mode_q   <= MODE_GEN;
        dir_q    <= 1'b0;
      end else if (is_start) begin
        active_q <= 1'b1;
        mode_q   <= start_mode;
        dir_q    <= start_dir;
      end else if (is_stop && active_q && mode_q == MODE_MULTI) begin
        active_q <= 1'b0;
      end else if (active_q && eot_mode && eot_in) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
        last_q   <= 1'b1;
      end else if (active_q && !eot_mode && cnt_zero) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
      end
    end
  end

  assign active   = active_q;
  assign mode     = mode_q;
  assign dir      = dir_q;
  assign done     = done_q;
  assign last_pkt = last_q;

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !active_q); // R7
  AST_STOP_MULTI: assert property (@(posedge clk) disable iff (!rst_n)
    is_stop && !clr && active_q && mode_q == MODE_MULTI |=> !active_q && !done_q); // R9
  AST_EOT_END: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && eot_mode && eot_in && !clr && !is_start |=> !active_q && done_q && last_q); // R11
  AST_LAST_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    last_q |-> done_q); // R11
  AST_START_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    is_start && !clr |=> active_q && dir_q == $past(start_dir)); // R4
endmodule

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter
  import dxc_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int BYTE_W   = 8,
  parameter int PIO_STEP = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_rst,
  input  logic                 reg_wr,
  input  logic [1:0]           reg_addr,
  input  logic [BYTE_W-1:0]    reg_wdata,
  output logic [BYTE_W-1:0]    reg_rdata,
  input  logic                 cmd_valid,
  input  logic [7:0]           cmd_code,
  input  logic                 cfg_cnt_dis,
  input  logic                 cfg_slave,
  input  logic                 beat_valid,
  output logic                 beat_ready,
  input  logic                 eot_in,
  output logic                 xfer_active,
  output logic [1:0]           xfer_mode,
  output logic                 xfer_dir,
  output logic                 xfer_done,
  output logic                 last_pkt_valid
);
  localparam int STEP_W = $clog2(PIO_STEP + 1);

  logic       is_start, is_reset, is_stop, start_dir, clr;
  xfer_mode_e start_mode;
  logic       dec_en, cnt_zero;
  logic [STEP_W-1:0] step;
  logic [CNT_W-1:0]  cnt;
  logic       rsv_cmd;

  assign clr     = bus_rst || is_reset;
  assign rsv_cmd = cmd_valid && !(cmd_code <= CMD_START_LAST) &&
                   cmd_code != CMD_RESET && cmd_code != CMD_STOP;

  dxc_cmd_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .is_start  (is_start),
    .is_reset  (is_reset),
    .is_stop   (is_stop),
    .start_mode(start_mode),
    .start_dir (start_dir)
  );

  dxc_count_reg #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .STEP_W(STEP_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .dec_en  (dec_en),
    .step    (step),
    .cnt     (cnt),
    .cnt_zero(cnt_zero),
    .rd_byte (reg_rdata)
  );

  dxc_xfer_ctrl #(.PIO_STEP(PIO_STEP), .STEP_W(STEP_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .is_start   (is_start),
    .is_stop    (is_stop),
    .start_mode (start_mode),
    .start_dir  (start_dir),
    .cfg_cnt_dis(cfg_cnt_dis),
    .cfg_slave  (cfg_slave),
    .beat_valid (beat_valid),
    .eot_in     (eot_in),
    .cnt_zero   (cnt_zero),
    .beat_ready (beat_ready),
    .dec_en     (dec_en),
    .step       (step),
    .active     (xfer_active),
    .mode       (xfer_mode),
    .dir        (xfer_dir),
    .done       (xfer_done),
    .last_pkt   (last_pkt_valid)
  );

  AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_cmd && !bus_rst && !xfer_active |=> !xfer_active && $stable(xfer_mode) && $stable(cnt)); // R10
  AST_BUS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> !xfer_active && cnt == '0); // R3
  AST_IDLE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_active |-> !beat_ready); // R13
endmodule

// File: tb/dma_xfer_counter_tb_top.sv
module dma_xfer_counter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0, bus_rst = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_code = '0;
  logic cfg_cnt_dis = 1'b0, cfg_slave = 1'b0, beat_valid = 1'b0, eot_in = 1'b0;
  logic beat_ready, xfer_active, xfer_dir, xfer_done, last_pkt_valid;
  logic [1:0] xfer_mode;

  int n_chk = 0, n_bad = 0, done_seen = 0, last_seen = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_xfer_counter dut_i (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cfg_cnt_dis(cfg_cnt_dis), .cfg_slave(cfg_slave), .beat_valid(beat_valid),
    .beat_ready(beat_ready), .eot_in(eot_in), .xfer_active(xfer_active),
    .xfer_mode(xfer_mode), .xfer_dir(xfer_dir), .xfer_done(xfer_done),
    .last_pkt_valid(last_pkt_valid)
  );

  always @(negedge clk) begin
    if (xfer_done) done_seen++;
    if (last_pkt_valid) last_seen++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr_byte(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic load_count(input logic [31:0] v);
    for (int b = 0; b < 4; b++) wr_byte(2'(b), v[b*8 +: 8]);
  endtask

  task automatic rd_count(output logic [31:0] v);
    v = '0;
    for (int b = 0; b < 4; b++) begin
      reg_addr = 2'(b); #1;
      v[b*8 +: 8] = reg_rdata;
    end
  endtask

  task automatic issue(input logic [7:0] c);
    cmd_valid = 1'b1; cmd_code = c;
    tick();
    cmd_valid = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    logic [31:0] v;
    int acc, d0, l0, exp_beats;
    int totals [6] = '{0, 1, 2, 3, 4, 7};
    repeat (3) tick();
    rd_count(v);
    check("R3 reset count", v, 0);
    check("R3 reset active", xfer_active, 0);
    check("R3 reset ready", beat_ready, 0);
    check("R3 reset done", xfer_done, 0);
    rst_n = 1'b1;
    tick();

    // R4 R5 R6 R7 R13 sweep over start codes and totals
    for (int c = 0; c < 8; c++) begin
      for (int t = 0; t < 6; t++) begin
        load_count(32'(totals[t]));
        rd_count(v);
        check("R1 live read", v, 32'(totals[t]));
        issue(8'(c));
        check("R4 active", xfer_active, 1);
        check("R4 mode", xfer_mode, 32'(c >> 1));
        check("R4 dir", xfer_dir, 32'(c & 1));
        d0 = done_seen; acc = 0;
        for (int i = 0; i < 40; i++) begin
          if (!xfer_active) break;
          beat_valid = (i % 3 != 2);
          if (beat_valid && beat_ready) acc++;
          tick();
        end
        beat_valid = 1'b0;
        tick();
        exp_beats = ((c >> 1) == 2) ? (totals[t] + 1) / 2 : totals[t];
        check("R5 R6 beats", acc, exp_beats);
        check("R7 done pulse", done_seen - d0, 1);
        check("R7 idle", xfer_active, 0);
        rd_count(v);
        check("R6 end count", v, 0);
      end
    end

    // R2 staging versus live load
    load_count(32'h11223344);
    wr_byte(0, 8'hAA);
    rd_count(v);
    check("R2 stage only", v, 32'h11223344);
    wr_byte(3, 8'h55);
    rd_count(v);
    check("R2 top load", v, 32'h552233AA);

    // R8 reset command clears count and staging
    issue(8'h11);
    rd_count(v);
    check("R8 count cleared", v, 0);
    wr_byte(3, 8'h01);
    rd_count(v);
    check("R8 stage cleared", v, 32'h01000000);

    // R12 eot ignored while counting; R10 reserved codes; R9 stop ignored outside multi
    load_count(32'd5);
    issue(8'h02);
    eot_in = 1'b1; tick(); eot_in = 1'b0; tick();
    check("R12 eot ignored", xfer_active, 1);
    rd_count(v);
    check("R12 count kept", v, 5);
    issue(8'h20); issue(8'h0A); issue(8'hFF); issue(8'h10);
    check("R10 active kept", xfer_active, 1);
    check("R10 mode kept", xfer_mode, 1);
    rd_count(v);
    check("R10 count kept", v, 5);
    issue(8'h12);
    check("R9 stop ignored", xfer_active, 1);

    // R9 stop in multi-word mode
    issue(8'h06);
    beat_valid = 1'b1; tick(); tick(); beat_valid = 1'b0;
    d0 = done_seen;
    issue(8'h12);
    tick();
    check("R9 stopped", xfer_active, 0);
    check("R9 no done", done_seen - d0, 0);
    rd_count(v);
    check("R9 count kept", v, 3);

    // R13 valid low leaves count
    issue(8'h02);
    beat_valid = 1'b0; tick(); tick();
    rd_count(v);
    check("R13 no valid", v, 3);

    // R3 bus reset mid-transfer
    bus_rst = 1'b1; tick(); bus_rst = 1'b0;
    check("R3 bus active", xfer_active, 0);
    rd_count(v);
    check("R3 bus count", v, 0);

    // R11 external end with counter disabled
    cfg_cnt_dis = 1'b1; cfg_slave = 1'b1;
    load_count(32'd2);
    issue(8'h01);
    acc = 0;
    beat_valid = 1'b1;
    for (int i = 0; i < 5; i++) begin
      if (beat_ready) acc++;
      tick();
    end
    beat_valid = 1'b0;
    check("R11 beats taken", acc, 5);
    rd_count(v);
    check("R11 count frozen", v, 2);
    check("R11 still active", xfer_active, 1);
    d0 = done_seen; l0 = last_seen;
    eot_in = 1'b1; tick(); eot_in = 1'b0; tick();
    check("R11 ended", xfer_active, 0);
    check("R11 done pulse", done_seen - d0, 1);
    check("R11 last pulse", last_seen - l0, 1);

    // R12 options set but non-generic mode still counts
    load_count(32'd2);
    issue(8'h03);
    eot_in = 1'b1; tick(); eot_in = 1'b0;
    check("R12 eot other mode", xfer_active, 1);
    cfg_cnt_dis = 1'b0; cfg_slave = 1'b0;

    summary();
  end
endmodule